// File: doc/BRIEF.md
# Dual-Register Byte Shifter

This block moves the magnitude bytes of two sign-magnitude registers, an accumulator and an extension, by a whole number of bytes. Each register holds a sign bit and five 6-bit bytes. A mode code picks one of six shifts: left or right on the accumulator alone, left or right on the two registers joined as one 10-byte value, or a left or right rotation of that 10-byte value. For the joined value, the accumulator holds the high half.

A caller presents both registers, a mode and an unsigned byte count, then pulses `start` for one cycle. One cycle later the shifted registers appear on the outputs, and `out_valid` is high for that single cycle. The outputs then hold until the next strobe. The count may be much larger than the data width. Plain shifts saturate, so a large count clears the shifted bytes. Rotations reduce the count modulo ten.

Top module: `byte_pair_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `acc_out` and `ext_out` become zero and `out_valid` becomes low.
- R2: A `start` sampled high at an edge updates `acc_out` and `ext_out` at that edge and raises `out_valid` for that cycle only. With `start` low, the outputs keep their values and `out_valid` is low.
- R3: Bit 30 of each register is its sign (1 = negative). No mode ever changes a sign: each output sign equals the sign of the matching input.
- R4: Modes 0 and 1 copy `ext_in` unchanged to `ext_out`.
- R5: Mode 0 shifts the accumulator magnitude left by `count` bytes, and mode 1 shifts it right. Zero bytes fill the vacated places and bytes pushed out are lost, so a count of 5 or more clears the magnitude. Byte 1, the most significant, is bits 29:24, and byte 5 is bits 5:0.
- R6: Modes 2 (left) and 3 (right) shift the 10-byte value formed by the accumulator magnitude (high) and the extension magnitude (low). Zero fill applies, and a count of 10 or more clears both magnitudes. Example: +1 2 3 4 5 / -6 7 8 9 10 shifted right by 1 gives +0 1 2 3 4 / -5 6 7 8 9.
- R7: Modes 4 (left) and 5 (right) rotate the same 10-byte value. Bytes leaving one end re-enter at the other, and the count is taken modulo 10, so a count of 501 gives the same result as a count of 1.
- R8: A count of 0 leaves both magnitudes unchanged in every mode.
- R9: Mode codes 6 and 7 pass both registers through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| mode | input | 3 | Shift mode code, 0 to 7 |
| count | input | 12 | Unsigned shift distance in bytes |
| acc_in | input | 31 | Accumulator: sign in bit 30, five bytes below it |
| ext_in | input | 31 | Extension: sign in bit 30, five bytes below it |
| acc_out | output | 31 | Shifted accumulator |
| ext_out | output | 31 | Shifted extension |
| out_valid | output | 1 | High in the cycle after an accepted strobe |

## Verification
The hardest cases are at the far end of the count range. These are rotations whose count is many multiples of ten plus a small residue, and plain shifts whose count sits just at, just below or far above the saturation width. The stimulus uses counts 4, 5, 9, 10, 501 and 4095 on distinct byte patterns in each register, so a misplaced byte shows up in the result. It also sends strobes back to back, which exposes any residue that leaks from one request into the next.

// File: rtl/bsh_pkg.sv
// Shared mode codes and decoded control for the dual-register byte shifter.
// Assumes a 3-bit mode field; codes 6 and 7 decode to pass-through.
package bsh_pkg;

    localparam logic [2:0] MODE_ACC_L  = 3'd0;
    localparam logic [2:0] MODE_ACC_R  = 3'd1;
    localparam logic [2:0] MODE_PAIR_L = 3'd2;
    localparam logic [2:0] MODE_PAIR_R = 3'd3;
    localparam logic [2:0] MODE_ROT_L  = 3'd4;
    localparam logic [2:0] MODE_ROT_R  = 3'd5;

    typedef struct packed {
        logic pass;      // leave both registers as they are
        logic acc_only;  // shift the accumulator alone
        logic left;      // direction toward the most significant byte
        logic circ;      // rotate instead of zero fill
    } shift_ctl_t;

    // Turns a mode code into shift controls.
    function automatic shift_ctl_t decode_mode(input logic [2:0] m);
        shift_ctl_t c;
        c.pass     = (m > MODE_ROT_R);
        c.acc_only = (m == MODE_ACC_L) || (m == MODE_ACC_R);
        c.left     = (m == MODE_ACC_L) || (m == MODE_PAIR_L) || (m == MODE_ROT_L);
        c.circ     = (m == MODE_ROT_L) || (m == MODE_ROT_R);
        return c;
    endfunction

endpackage

// File: rtl/bsh_count_prep.sv
// Reduces a raw byte count to the stage-select amounts of the barrels.
// Plain shifts saturate at the register width in bytes; rotations take the
// count modulo the pair width. Assumes the count is unsigned.
module bsh_count_prep #(
    parameter int CNT_W      = 12,
    parameter int ACC_BYTES  = 5,
    parameter int PAIR_BYTES = 10,
    parameter int ACC_AW     = 3,
    parameter int PAIR_AW    = 4
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic               circ,
    output logic [ACC_AW-1:0]  acc_amt,
    output logic [PAIR_AW-1:0] pair_amt
);
    logic [CNT_W-1:0] rem;

    // Residue of the count for a rotation over the pair.
    always_comb rem = cnt % CNT_W'(PAIR_BYTES);

    // Saturated amount for the accumulator-only barrel.
    always_comb begin
        if (cnt >= CNT_W'(ACC_BYTES)) acc_amt = ACC_AW'(ACC_BYTES);
        else                          acc_amt = cnt[ACC_AW-1:0];
    end

    // Pair amount: residue for rotation, saturation otherwise.
    always_comb begin
        if (circ)                              pair_amt = rem[PAIR_AW-1:0];
        else if (cnt >= CNT_W'(PAIR_BYTES))    pair_amt = PAIR_AW'(PAIR_BYTES);
        else                                   pair_amt = cnt[PAIR_AW-1:0];
    end

endmodule

// File: rtl/bsh_barrel.sv
// Logarithmic byte barrel: stage k moves the data by 2**k bytes when amt[k]
// is set. Assumes amt never exceeds NBYTES, and that amt < NBYTES when circ
// is set, so that composed stage rotations equal one rotation.
module bsh_barrel #(
    parameter int NBYTES = 10,
    parameter int BYTE_W = 6,
    parameter int AW     = 4
) (
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic [AW-1:0]            amt,
    input  logic                     left,
    input  logic                     circ,
    output logic [NBYTES*BYTE_W-1:0] dout
);
    localparam int TOT = NBYTES * BYTE_W;

    logic [TOT-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        localparam int SB = SH * BYTE_W;
        logic [TOT-1:0] moved;

        if (SH < NBYTES) begin : g_part
            logic [TOT-1:0] shl, shr, rl, rr;
            assign shl = {stg[k][TOT-1-SB:0], {SB{1'b0}}};
            assign shr = {{SB{1'b0}}, stg[k][TOT-1:SB]};
            assign rl  = {stg[k][TOT-1-SB:0], stg[k][TOT-1 -: SB]};
            assign rr  = {stg[k][SB-1:0], stg[k][TOT-1:SB]};
            // Picks this stage's moved value for the requested kind of shift.
            always_comb begin
                if (circ) moved = left ? rl : rr;
                else      moved = left ? shl : shr;
            end
        end else begin : g_full
            // A full-width move clears a plain shift and leaves a rotation intact.
            always_comb moved = circ ? stg[k] : '0;
        end

        assign stg[k+1] = amt[k] ? moved : stg[k];
    end

    assign dout = stg[AW];

endmodule

// File: rtl/byte_pair_shifter.sv
// Top of the dual-register byte shifter. Decodes the mode, prepares the
// counts, runs a 5-byte and a 10-byte barrel in parallel and registers the
// selected result one cycle after start. Signs pass through untouched.
module byte_pair_shifter
    import bsh_pkg::*;
#(
    parameter int BYTE_W     = 6,
    parameter int WORD_BYTES = 5,
    parameter int CNT_W      = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [2:0]                   mode,
    input  logic [CNT_W-1:0]             count,
    input  logic [BYTE_W*WORD_BYTES:0]   acc_in,
    input  logic [BYTE_W*WORD_BYTES:0]   ext_in,
    output logic [BYTE_W*WORD_BYTES:0]   acc_out,
    output logic [BYTE_W*WORD_BYTES:0]   ext_out,
    output logic                         out_valid
);
    localparam int MAG_W      = BYTE_W * WORD_BYTES;
    localparam int PAIR_BYTES = 2 * WORD_BYTES;
    localparam int ACC_AW     = $clog2(WORD_BYTES + 1);
    localparam int PAIR_AW    = $clog2(PAIR_BYTES + 1);

    shift_ctl_t         ctl;
    logic [ACC_AW-1:0]  acc_amt;
    logic [PAIR_AW-1:0] pair_amt;
    logic [MAG_W-1:0]   acc_only_mag;
    logic [2*MAG_W-1:0] pair_mag;
    logic [MAG_W-1:0]   acc_nxt, ext_nxt;

    // Decodes the mode code into controls.
    always_comb ctl = decode_mode(mode);

    bsh_count_prep #(
        .CNT_W(CNT_W), .ACC_BYTES(WORD_BYTES), .PAIR_BYTES(PAIR_BYTES),
        .ACC_AW(ACC_AW), .PAIR_AW(PAIR_AW)
    ) i_count (
        .cnt(count), .circ(ctl.circ), .acc_amt(acc_amt), .pair_amt(pair_amt)
    );

    bsh_barrel #(.NBYTES(WORD_BYTES), .BYTE_W(BYTE_W), .AW(ACC_AW)) i_acc_barrel (
        .din(acc_in[MAG_W-1:0]), .amt(acc_amt), .left(ctl.left),
        .circ(1'b0), .dout(acc_only_mag)
    );

    bsh_barrel #(.NBYTES(PAIR_BYTES), .BYTE_W(BYTE_W), .AW(PAIR_AW)) i_pair_barrel (
        .din({acc_in[MAG_W-1:0], ext_in[MAG_W-1:0]}), .amt(pair_amt),
        .left(ctl.left), .circ(ctl.circ), .dout(pair_mag)
    );

    // Chooses the magnitudes to load from pass-through, single or pair path.
    always_comb begin
        if (ctl.pass) begin
            acc_nxt = acc_in[MAG_W-1:0];
            ext_nxt = ext_in[MAG_W-1:0];
        end else if (ctl.acc_only) begin
            acc_nxt = acc_only_mag;
            ext_nxt = ext_in[MAG_W-1:0];
        end else begin
            acc_nxt = pair_mag[2*MAG_W-1:MAG_W];
            ext_nxt = pair_mag[MAG_W-1:0];
        end
    end

    // Result register: loads on start, holds otherwise, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out   <= '0;
            ext_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= start;
            if (start) begin
                acc_out <= {acc_in[MAG_W], acc_nxt};
                ext_out <= {ext_in[MAG_W], ext_nxt};
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);

    // R2
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_out) && $stable(ext_out)));

    // R3
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_out[MAG_W] == $past(acc_in[MAG_W]) &&
                   ext_out[MAG_W] == $past(ext_in[MAG_W])));

    // R4
    ext_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (mode == MODE_ACC_L || mode == MODE_ACC_R)) |=> ext_out == $past(ext_in));

    // R7
    rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (mode == MODE_ROT_L || mode == MODE_ROT_R)) |=>
        ($countones({acc_out[MAG_W-1:0], ext_out[MAG_W-1:0]}) ==
         $countones($past({acc_in[MAG_W-1:0], ext_in[MAG_W-1:0]}))));

    // R8
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && count == '0) |=> (acc_out == $past(acc_in) && ext_out == $past(ext_in)));

endmodule

// File: tb/test_byte_pair_shifter.sv
// Scoreboard bench: the driver computes the expected words and queues them;
// the monitor compares each result as out_valid shows it.
module test_byte_pair_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [11:0] count = '0;
    logic [30:0] acc_in = '0, ext_in = '0;
    logic [30:0] acc_out, ext_out;
    logic        out_valid;

    typedef struct {
        logic [30:0] ea;
        logic [30:0] ee;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [30:0] last_ea = '0, last_ee = '0;

    always #5 clk = ~clk;

    byte_pair_shifter i_byte_pair_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
        .acc_in(acc_in), .ext_in(ext_in), .acc_out(acc_out), .ext_out(ext_out),
        .out_valid(out_valid)
    );

    function automatic logic [30:0] word(input logic s, input int b1, input int b2,
                                         input int b3, input int b4, input int b5);
        return {s, 6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
    endfunction

    // Expected result from the requirement text; index 0 is the top byte.
    task automatic model(input int md, input int cnt, input logic [30:0] a,
                         input logic [30:0] e, output logic [30:0] ea,
                         output logic [30:0] ee);
        int b[10];
        int r[10];
        int n;
        int k;
        for (int i = 0; i < 5; i++) begin
            b[i]   = int'(a[29-6*i -: 6]);
            b[5+i] = int'(e[29-6*i -: 6]);
        end
        for (int i = 0; i < 10; i++) r[i] = b[i];
        n = (md < 2) ? 5 : 10;
        k = cnt % 10;
        if (md <= 5) begin
            for (int i = 0; i < n; i++) begin
                case (md)
                    0, 2: r[i] = (i + cnt < n) ? b[i+cnt] : 0;
                    1, 3: r[i] = (i - cnt >= 0) ? b[i-cnt] : 0;
                    4:    r[i] = b[(i + k) % 10];
                    default: r[i] = b[(i - k + 10) % 10];
                endcase
            end
        end
        ea = word(a[30], r[0], r[1], r[2], r[3], r[4]);
        ee = word(e[30], r[5], r[6], r[7], r[8], r[9]);
    endtask

    // Driver: presents one request at a falling edge and queues its expectation.
    task automatic send(input int md, input int cnt, input logic [30:0] a,
                        input logic [30:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        mode   = 3'(md);
        count  = 12'(cnt);
        acc_in = a;
        ext_in = e;
        start  = 1'b1;
        model(md, cnt, a, e, x.ea, x.ee);
        x.tag = tag;
        last_ea = x.ea;
        last_ee = x.ee;
        sb_q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pops and compares each expectation when a result appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected out_valid: actual %h/%h expected none",
                         acc_out, ext_out);
            end else begin
                exp_t x;
                x = sb_q.pop_front();
                if (acc_out !== x.ea || ext_out !== x.ee) begin
                    n_bad++;
                    $display("FAIL %s: actual %h/%h expected %h/%h",
                             x.tag, acc_out, ext_out, x.ea, x.ee);
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    logic [30:0] pa, pe, na, ne;

    initial begin
        pa = word(1'b0, 1, 2, 3, 4, 5);
        pe = word(1'b1, 6, 7, 8, 9, 10);
        na = word(1'b1, 63, 17, 42, 5, 33);
        ne = word(1'b0, 21, 0, 58, 12, 7);

        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (acc_out !== '0 || ext_out !== '0 || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual %h/%h/%b expected 0/0/0", acc_out, ext_out, out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        send(3, 1, pa, pe, "R6 pair right 1");
        send(0, 2, pa, pe, "R5 acc left 2, R4 ext kept");
        send(1, 2, pa, pe, "R5 acc right 2, R4 ext kept");
        send(0, 4, na, ne, "R5 acc left 4");
        send(0, 5, na, ne, "R5 acc left 5 clears");
        send(1, 4095, na, ne, "R5 acc right 4095 clears");
        send(2, 9, pa, pe, "R6 pair left 9");
        send(2, 10, pa, pe, "R6 pair left 10 clears");
        send(3, 4095, na, ne, "R6 pair right 4095 clears");
        send(5, 4, pa, pe, "R7 rotate right 4");
        send(4, 501, na, ne, "R7 rotate left 501");
        send(4, 1, na, ne, "R7 rotate left 1");
        send(5, 4095, pa, pe, "R7 rotate right 4095");
        send(4, 10, na, ne, "R7 rotate left 10");
        send(1, 3, word(1'b1, 9, 9, 9, 9, 9), word(1'b1, 1, 1, 1, 1, 1), "R3 negative signs kept");
        send(3, 7, word(1'b1, 9, 9, 9, 9, 9), word(1'b0, 1, 1, 1, 1, 1), "R3 mixed signs kept");
        for (int m = 0; m < 6; m++) send(m, 0, na, ne, "R8 zero count");
        send(6, 3, na, ne, "R9 mode 6 pass");
        send(7, 12, pa, pe, "R9 mode 7 pass");
        for (int m = 0; m < 6; m++)
            for (int c = 1; c < 13; c++)
                send(m, c, (c % 2 == 0) ? na : pa, (c % 2 == 0) ? ne : pe, "sweep R5 R6 R7");
        send(2, 3, na, pe, "R2 last before hold");
        idle();
        @(negedge clk);
        // R2: outputs hold and out_valid stays low while inputs change
        acc_in = pa;
        ext_in = ne;
        mode = 3'd4;
        count = 12'd3;
        repeat (3) @(negedge clk);
        n_chk++;
        if (acc_out !== last_ea || ext_out !== last_ee || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 hold: actual %h/%h/%b expected %h/%h/0",
                     acc_out, ext_out, out_valid, last_ea, last_ee);
        end
        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing results: actual %0d pending expected 0", sb_q.size());
        end
        summary();
    end

endmodule